// File: doc/BRIEF.md
# Interrupt Level Threshold Gate

This block decides, cycle by cycle, whether a pending external interrupt request is to be taken by the processor. Requests arrive as a vector with one bit per level, for levels 1 to 15. Level 15 has the highest priority, and there is no level-0 request. The block picks the highest pending level. It compares that level against a programmable mask threshold and gates the result with the global interrupt enable.

When a request wins, the block emits a one-cycle take strobe, the winning level and a trap type code derived from that level. The source holds its request bit until it clears it, so the strobe does not repeat for a request that is already held. A new strobe comes only when the winning level changes, or when eligibility is lost and later regained.

The mask threshold is a small register written through a write-enable and data pair. It can also be read back.

Top module: `irq_level_gate`

## Requirements
- R1: After reset `take_o` is 0, `take_lvl_o` and `take_tt_o` are 0, and the mask threshold `mask_lvl_o` reads 15, so every request is blocked.
- R2: When `mask_wr_en` is high at a rising edge, `mask_lvl_o` shows `mask_wr_data` after that edge. The new threshold governs decisions from the following edge on.
- R3: Bit i of `req_pend` is a request at level i+1. Among the pending bits, the highest level is selected and reported in `take_lvl_o`.
- R4: A request whose level is less than or equal to the mask threshold produces no take, and this includes the equal case.
- R5: With a threshold of 0, a lone level-1 request is taken.
- R6: With a threshold of 15, no request pattern produces a take.
- R7: While `int_en` is low, no take occurs. Raising `int_en` while an eligible request is held produces a take at the next edge.
- R8: With each take, `take_tt_o` equals 0x40 plus the taken level. Whenever `take_o` is low, `take_lvl_o` and `take_tt_o` are 0.
- R9: `take_o` is a one-cycle pulse registered one edge after the inputs that cause it. A request held steadily gives exactly one pulse. A change of the winning level while eligible gives a new pulse, and so does a request that is dropped and then presented again.
- R10: Lowering the threshold below the level of a request that is already pending causes that request to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | 15 | Pending requests; bit i is level i+1 |
| int_en | input | 1 | Global interrupt enable |
| mask_wr_en | input | 1 | Write strobe for the mask threshold |
| mask_wr_data | input | 4 | New mask threshold |
| mask_lvl_o | output | 4 | Current mask threshold |
| take_o | output | 1 | One-cycle take strobe |
| take_lvl_o | output | 4 | Level taken (0 when idle) |
| take_tt_o | output | 8 | Trap type of the taken level (0 when idle) |

## Verification
The bench targets the equal-to-threshold case. A design that compares with `>=` takes the request there, when it should ignore it. It also targets the two extreme thresholds, 0 and 15, which an off-by-one in the compare or in the reset value would open or close wrongly.

Several requests are presented together to check the priority. A design that encodes toward the lowest bit would report the wrong level and trap type. The strobe rules are checked against held requests, a rising higher level, a drop and reassertion, an enable raised late and a threshold lowered under a held request. A design that takes a level instead of a pulse, or that never re-arms, would show extra or missing strobes.

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int          LVL_W   = 4,
  parameter logic [7:0]  TT_BASE = 8'h40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<LVL_W)-2:0]         req_pend,
  input  logic                          int_en,
  input  logic                          mask_wr_en,
  input  logic [LVL_W-1:0]              mask_wr_data,
  output logic [LVL_W-1:0]              mask_lvl_o,
  output logic                          take_o,
  output logic [LVL_W-1:0]              take_lvl_o,
  output logic [7:0]                    take_tt_o
);
  localparam int NREQ = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NREQ);

  logic [LVL_W-1:0] mask_q, best, best_q;
  logic             elig, elig_q, fresh;

  always_comb begin
    best = '0;
    for (int i = 0; i < NREQ; i++)
      if (req_pend[i]) best = LVL_W'(i + 1);
  end

  assign elig  = int_en && (best > mask_q);
  assign fresh = elig && (!elig_q || best != best_q);
  assign mask_lvl_o = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= LVL_MAX;
      elig_q     <= 1'b0;
      best_q     <= '0;
      take_o     <= 1'b0;
      take_lvl_o <= '0;
      take_tt_o  <= '0;
    end else begin
      if (mask_wr_en) mask_q <= mask_wr_data;
      elig_q     <= elig;
      best_q     <= best;
      take_o     <= fresh;
      take_lvl_o <= fresh ? best : '0;
      take_tt_o  <= fresh ? TT_BASE + 8'(best) : 8'h00;
    end
  end

  // R4
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> take_lvl_o > $past(mask_q));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(int_en));

  // R8
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> take_tt_o == TT_BASE + 8'(take_lvl_o));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (take_lvl_o == '0 && take_tt_o == 8'h00));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!take_o || take_lvl_o != $past(take_lvl_o)));

  // R6
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == LVL_MAX) |-> !take_o);
endmodule

// File: tb/irq_level_gate_bench.sv
module irq_level_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] req_pend = '0;
  logic        int_en = 1'b0;
  logic        mask_wr_en = 1'b0;
  logic [3:0]  mask_wr_data = '0;
  logic [3:0]  mask_lvl_o, take_lvl_o;
  logic        take_o;
  logic [7:0]  take_tt_o;
  int nvec = 0, nbad = 0;

  always #5 clk = ~clk;

  irq_level_gate u_irq_level_gate (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .int_en(int_en),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_lvl_o(mask_lvl_o), .take_o(take_o),
    .take_lvl_o(take_lvl_o), .take_tt_o(take_tt_o));

  function automatic logic [14:0] lv(int n);
    return 15'(1) << (n - 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_take(string tag, int lvl);
    chk({tag, " take"}, int'(take_o), lvl != 0 ? 1 : 0);
    chk({tag, " level"}, int'(take_lvl_o), lvl);
    chk({tag, " tt"}, int'(take_tt_o), lvl != 0 ? 'h40 + lvl : 0);
  endtask

  task automatic set_mask(int v);
    mask_wr_en = 1'b1; mask_wr_data = 4'(v);
    step();
    mask_wr_en = 1'b0;
    chk("R2 mask readback", int'(mask_lvl_o), v);
  endtask

  task automatic idle();
    req_pend = '0; step(); step();
  endtask

  task automatic t_reset();
    expect_take("R1 reset", 0);
    chk("R1 mask reset", int'(mask_lvl_o), 15);
  endtask

  task automatic t_priority();
    int_en = 1; set_mask(0);
    req_pend = lv(3) | lv(9) | lv(5);
    step(); expect_take("R3 highest of 3,5,9", 9);
    step(); expect_take("R9 held no repeat", 0);
    idle();
  endtask

  task automatic t_equal();
    set_mask(6);
    req_pend = lv(6) | lv(2);
    step(); expect_take("R4 equal ignored", 0);
    step(); expect_take("R4 equal still ignored", 0);
    req_pend = req_pend | lv(7);
    step(); expect_take("R4 one above taken", 7);
    idle();
  endtask

  task automatic t_full_mask();
    set_mask(15);
    req_pend = '1;
    step(); expect_take("R6 all blocked", 0);
    step(); expect_take("R6 all blocked again", 0);
    idle();
  endtask

  task automatic t_open();
    set_mask(0);
    req_pend = lv(1);
    step(); expect_take("R5 level1 open mask", 1);
    idle();
  endtask

  task automatic t_enable();
    int_en = 0;
    req_pend = lv(12);
    step(); expect_take("R7 disabled", 0);
    step(); expect_take("R7 still disabled", 0);
    int_en = 1;
    step(); expect_take("R7 enable raised", 12);
    step(); expect_take("R7 no repeat", 0);
    idle();
  endtask

  task automatic t_higher();
    set_mask(2);
    req_pend = lv(4);
    step(); expect_take("R9 first", 4);
    step(); expect_take("R9 held", 0);
    req_pend = lv(4) | lv(11);
    step(); expect_take("R9 higher arrives", 11);
    step(); expect_take("R9 higher held", 0);
    req_pend = lv(4);
    step(); expect_take("R9 winner falls back", 4);
    idle();
  endtask

  task automatic t_unmask();
    set_mask(10);
    req_pend = lv(8);
    step(); expect_take("R10 masked", 0);
    set_mask(5);
    expect_take("R10 write edge", 0);
    step(); expect_take("R10 unmasked take", 8);
    idle();
  endtask

  task automatic t_reassert();
    set_mask(0);
    req_pend = lv(3);
    step(); expect_take("R9 first pulse", 3);
    step(); expect_take("R9 held", 0);
    req_pend = '0;
    step(); expect_take("R9 dropped", 0);
    req_pend = lv(3);
    step(); expect_take("R9 reassert pulse", 3);
    idle();
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    #1;
    t_reset();
    t_priority();
    t_equal();
    t_full_mask();
    t_open();
    t_enable();
    t_higher();
    t_unmask();
    t_reassert();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule